// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block takes in one byte at a time over a clock-synchronous serial link. It has a serial data input and a serial clock that is split into an input, an output and an output enable. In master mode the block makes the serial clock from the system clock through a divider that firmware sets, and it drives that clock out. In slave mode it leaves the clock line undriven. It takes edges from an external device instead, after a synchronizer. Bits arrive least-significant first and are captured on rising serial-clock edges. After the eighth edge the byte moves into a holding buffer and a completion flag is raised. That flag can also drive an interrupt.

Firmware uses one control word. It writes the word with a write strobe, and each write updates every control field. Every byte must be armed by its own trigger write. A control FSM has three states. OFF means disabled. READY means enabled and idle. RECV means shifting in a byte. The transitions are ENABLE (OFF to READY, on a write with receive-enable set), START (READY to RECV, on an accepted trigger), COMPLETE (RECV to READY, on the eighth rising edge) and DISABLE (READY or RECV to OFF, on any write with receive-enable clear). A DISABLE write clears the shift register and the bit counter. When that write also has transmit-enable clear, it clears the completion flag as well.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, rx_done, irq and sclk_oe are 0, sclk_out is 1 and rx_data is 0.
- R2: Control word fields are: bit 0 receive enable, bit 1 transmit enable, bit 2 interrupt enable, bit 3 master mode, bit 4 trigger (write 1 to start), bit 5 done acknowledge (write 1 to clear). A trigger is accepted only in READY with bit 0 also 1 in the same write. A trigger sent while the block is OFF (receive enable 0) starts nothing.
- R3: A write with bits 0 and 1 both 0 aborts any byte in progress. It clears the shift register, the bit counter and rx_done, and it leaves rx_data unchanged.
- R4: Data is captured least-significant bit first on each rising serial-clock edge. On the eighth edge the assembled byte (first bit at bit 0) appears on rx_data and rx_done goes to 1 in the same cycle.
- R5: In master mode, sclk_oe is 1 whenever the block is not OFF. sclk_out idles at 1 and each half period lasts clk_div+1 system cycles. The clock stops at 1 after the eighth rising edge.
- R6: In slave mode, sclk_oe is 0. Edges on sclk_in are counted only in RECV, after two-stage synchronization. Edges outside RECV have no effect.
- R7: irq is 1 exactly when rx_done is 1 and interrupt enable is set. It rises in the same cycle as rx_done.
- R8: rx_done is cleared by a write with bit 5 set or by an accepted trigger.
- R9: If completion and a clearing write fall in the same cycle, rx_done ends up 1.
- R10: A trigger written during RECV is ignored, and the byte in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word (fields in R2) |
| clk_div | input | DIVW | Master half-period minus one, in system cycles |
| sdi | input | 1 | Serial data input |
| sclk_in | input | 1 | Serial clock from the pin (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| rx_data | output | NBITS | Received byte buffer |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt request |

## Verification
Two events can fall in the same cycle: completion of a byte, which sets rx_done, and a firmware write that clears rx_done. The bench runs in slave mode and counts the synchronizer and edge-detector registers. This tells it the exact system-clock edge at which the eighth synchronized rise is captured. It then places an acknowledge write on that same edge. The check passes if rx_done reads 1 afterwards and the scoreboard still receives the correct byte.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_READY = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

    localparam int CTRL_W   = 6;
    localparam int CB_RXEN  = 0;
    localparam int CB_TXEN  = 1;
    localparam int CB_IRQEN = 2;
    localparam int CB_MST   = 3;
    localparam int CB_TRIG  = 4;
    localparam int CB_ACK   = 5;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int             W      = 2,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= INIT;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= INIT;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rxs_clkgen.sv
module rxs_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            sclk_o,
    output logic            rise_o
);
    logic [DIVW-1:0] cnt_q;
    logic            sclk_q;
    logic            flip;

    assign flip   = run && (cnt_q == div);
    assign rise_o = flip && !sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (flip) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIVW'(1);
        end
    end

    // R5: a sampling edge always leaves the clock high
    p_rise_leaves_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> sclk_q);
endmodule

// File: rtl/rxs_shift.sv
module rxs_shift #(
    parameter int NBITS = 8,
    localparam int CW   = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic             din,
    output logic [NBITS-1:0] word_o,
    output logic             full_o
);
    logic [NBITS-1:0] sreg_q;
    logic [CW-1:0]    cnt_q;

    assign word_o = {din, sreg_q[NBITS-1:1]};
    assign full_o = capture && (cnt_q == CW'(NBITS-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (capture) begin
            sreg_q <= word_o;
            cnt_q  <= full_o ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import rxs_pkg::*;
#(
    parameter int NBITS       = 8,
    parameter int DIVW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [DIVW-1:0]   clk_div,
    input  logic              sdi,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic [NBITS-1:0]  rx_data,
    output logic              rx_done,
    output logic              irq
);
    rx_state_e        state_q, state_d;
    logic             irq_en_q, mst_q, done_q;
    logic [NBITS-1:0] buf_q;
    logic             sclk_s, sdi_s, sclk_d;
    logic             m_sclk, m_rise, s_rise;
    logic             bit_rise, bit_din, capture, word_done, sh_clear, run;
    logic [NBITS-1:0] word;
    logic             wr_on, wr_off, full_reset, start, clr_req;

    // control write decode
    assign wr_on      = ctrl_we &&  ctrl_wdata[CB_RXEN];
    assign wr_off     = ctrl_we && !ctrl_wdata[CB_RXEN];
    assign full_reset = wr_off  && !ctrl_wdata[CB_TXEN];
    assign start      = wr_on && ctrl_wdata[CB_TRIG] && (state_q == ST_READY);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (wr_on)          state_d = ST_READY;
            ST_READY: if (wr_off)         state_d = ST_OFF;
                      else if (start)     state_d = ST_RECV;
            ST_RECV:  if (wr_off)         state_d = ST_OFF;
                      else if (word_done) state_d = ST_READY;
            default:                      state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output / datapath controls
    always_comb begin
        sh_clear = start || wr_off;
        bit_rise = mst_q ? m_rise : s_rise;
        bit_din  = mst_q ? sdi : sdi_s;
        capture  = (state_q == ST_RECV) && bit_rise;
        run      = mst_q && (state_q == ST_RECV);
        clr_req  = (ctrl_we && ctrl_wdata[CB_ACK]) || start || full_reset;
        sclk_oe  = mst_q && (state_q != ST_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            mst_q    <= 1'b0;
            sclk_d   <= 1'b1;
            done_q   <= 1'b0;
            buf_q    <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (ctrl_we) begin
                irq_en_q <= ctrl_wdata[CB_IRQEN];
                mst_q    <= ctrl_wdata[CB_MST];
            end
            if (word_done) begin
                done_q <= 1'b1;
                buf_q  <= word;
            end else if (clr_req) begin
                done_q <= 1'b0;
            end
        end
    end

    assign s_rise   = sclk_s && !sclk_d;
    assign sclk_out = m_sclk;
    assign rx_data  = buf_q;
    assign rx_done  = done_q;
    assign irq      = done_q && irq_en_q;

    rxs_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, sdi}),
        .q     ({sclk_s, sdi_s})
    );

    rxs_clkgen #(.DIVW(DIVW)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div    (clk_div),
        .sclk_o (m_sclk),
        .rise_o (m_rise)
    );

    rxs_shift #(.NBITS(NBITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sh_clear),
        .capture (capture),
        .din     (bit_din),
        .word_o  (word),
        .full_o  (word_done)
    );

    // R2: no reception can begin straight out of OFF
    p_no_start_from_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (state_q != ST_RECV));
    // R4: the flag only rises as a byte in RECV finishes
    p_done_from_recv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_RECV));
    // R5: the generated clock idles high while READY
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> sclk_out);
    // R9: completion beats a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && clr_req) |=> done_q);
endmodule

// File: tb/sim_sync_serial_rx.sv
module sim_sync_serial_rx;
    localparam int NB = 8;
    localparam int DW = 8;
    localparam logic [5:0] RXEN = 6'h01, IRQEN = 6'h04, MST = 6'h08,
                           TRIG = 6'h10, ACK = 6'h20;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [5:0]    ctrl_wdata = '0;
    logic [DW-1:0] clk_div = '0;
    logic          sdi = 1'b0, sclk_in = 1'b1;
    logic          sclk_out, sclk_oe, rx_done, irq;
    logic [NB-1:0] rx_data;

    sync_serial_rx #(.NBITS(NB), .DIVW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .clk_div(clk_div), .sdi(sdi), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .rx_data(rx_data), .rx_done(rx_done), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    typedef struct { logic [7:0] data; logic irq; } exp_t;
    exp_t exp_q[$];
    exp_t e;
    logic done_prev = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [5:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic i);
        exp_t x; x.data = b; x.irq = i; exp_q.push_back(x);
    endtask

    task automatic slave_bits(input logic [7:0] b, input int first, input int last);
        for (int i = first; i <= last; i++) begin
            sclk_in = 1'b0; sdi = b[i];
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic master_byte(input logic [7:0] b, output int lowlen);
        int cnt;
        lowlen = 0;
        for (int i = 0; i < 8; i++) begin
            do @(negedge clk); while (sclk_out !== 1'b0);
            sdi = b[i];
            cnt = 1;
            forever begin
                @(negedge clk);
                if (sclk_out === 1'b1) break;
                cnt++;
            end
            lowlen = cnt;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_done && !done_prev) begin
            if (exp_q.size() == 0) check("R4 unexpected completion", 1, 0);
            else begin
                e = exp_q.pop_front();
                check("R4 byte LSB first", rx_data, e.data);
                check("R7 irq with flag", irq, e.irq);
            end
        end
        done_prev = rx_done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_done", rx_done, 0);
        check("R1 irq", irq, 0);
        check("R1 sclk_oe", sclk_oe, 0);
        check("R1 sclk_out", sclk_out, 1);
        check("R1 rx_data", rx_data, 0);

        // R2: trigger while disabled
        wr(TRIG);
        slave_bits(8'hFF, 0, 7);
        check("R2 trig with enable 0", rx_done, 0);
        wr(RXEN | TRIG);
        slave_bits(8'hFF, 0, 7);
        check("R2 trig from OFF", rx_done, 0);
        check("R2 buffer untouched", rx_data, 0);

        // slave byte with interrupt
        wr(RXEN | IRQEN | TRIG); push(8'hA5, 1'b1);
        slave_bits(8'hA5, 0, 7);
        check("R7 irq high", irq, 1);
        check("R6 slave oe", sclk_oe, 0);

        wr(RXEN | IRQEN | ACK);
        check("R8 ack clears", rx_done, 0);
        check("R7 irq drops", irq, 0);

        wr(RXEN | TRIG); push(8'h3C, 1'b0);
        slave_bits(8'h3C, 0, 7);
        check("R7 irq masked", irq, 0);
        check("R4 done set", rx_done, 1);

        // R8 retrigger, then R3 full reset mid-byte
        wr(RXEN | TRIG);
        check("R8 retrigger clears", rx_done, 0);
        slave_bits(8'h96, 0, 3);
        wr(6'h00);
        check("R3 flag cleared", rx_done, 0);
        check("R3 buffer kept", rx_data, 8'h3C);
        wr(RXEN); wr(RXEN | TRIG); push(8'h5A, 1'b0);
        slave_bits(8'h5A, 0, 7);
        check("R3 fresh byte after reset", rx_done, 1);

        // R10 trigger during reception
        wr(RXEN | TRIG); push(8'hC3, 1'b0);
        slave_bits(8'hC3, 0, 2);
        wr(RXEN | TRIG);
        slave_bits(8'hC3, 3, 7);
        check("R10 byte completes", rx_done, 1);

        // R9 completion and ack in same cycle
        wr(RXEN | TRIG); push(8'h81, 1'b0);
        slave_bits(8'h81, 0, 6);
        sclk_in = 1'b0; sdi = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (2) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = RXEN | ACK;
        @(negedge clk); ctrl_we = 1'b0;
        check("R9 set wins", rx_done, 1);
        repeat (4) @(negedge clk);

        // master mode
        clk_div = 8'd3;
        wr(RXEN | MST | IRQEN | ACK);
        check("R5 master oe", sclk_oe, 1);
        check("R5 idle high", sclk_out, 1);
        wr(RXEN | MST | IRQEN | TRIG); push(8'h4E, 1'b1);
        master_byte(8'h4E, len);
        check("R5 half period div3", len, 4);
        repeat (10) @(negedge clk);
        check("R5 stops high", sclk_out, 1);
        check("R5 done master", rx_done, 1);

        clk_div = 8'd0;
        wr(RXEN | MST | TRIG); push(8'hB7, 1'b0);
        master_byte(8'hB7, len);
        check("R5 half period div0", len, 1);
        repeat (6) @(negedge clk);

        // R6 slave edges outside RECV ignored
        wr(RXEN | ACK);
        check("R6 oe off in slave", sclk_oe, 0);
        slave_bits(8'hFF, 0, 7);
        check("R6 no capture without trigger", rx_done, 0);
        check("R6 buffer kept", rx_data, 8'hB7);

        check("R4 all bytes seen", exp_q.size(), 0);
        finish_up();
    end
endmodule